// File: doc/BRIEF.md
# Four-Rail Undervoltage/Overvoltage Fault Sequencer

This block is the digital decision logic behind a four-rail power supervisor. Each rail arrives as two comparator results that have already been synchronized: one says the high divider tap has dropped below threshold, the other says the low divider tap has risen above it. Rails 1 and 2 are always positive supplies. A polarity-select code decides whether rails 3 and 4 are positive or negative; on a negative rail the two comparator meanings trade places. The block merges the per-rail conditions into one active-low undervoltage output and one active-low overvoltage output.

Each output has its own down-counter. The counter keeps the output asserted for a programmable number of clock cycles after the last fault of that kind clears, and a fresh fault reloads it. A timer-bypass input removes that hold time. A supply-lockout input forces undervoltage on and overvoltage off. A build parameter selects one of two variants. In the latch variant, an overvoltage can be captured until a clear input is raised. In the disable variant, a disable input silences both outputs, except that supply lockout still asserts undervoltage.

Top module: `rail_supervisor`

## Requirements
- R1: Rails 1 and 2 (bit 0 and bit 1 of each comparator vector) are always positive: a set `hi_below` bit is an undervoltage and a set `lo_above` bit is an overvoltage.
- R2: `pol_sel` sets the polarity of rails 3 and 4 (bits 2 and 3): 2'b00 makes both negative, 2'b01 makes rail 3 positive and rail 4 negative, and 2'b10 or 2'b11 makes both positive.
- R3: On a negative rail the meanings swap: a set `lo_above` bit is an undervoltage and a set `hi_below` bit is an overvoltage.
- R4: `uv_n` is low whenever any rail has an undervoltage, and `ov_n` is low whenever any rail has an overvoltage. The output changes in the same cycle as the input, with no register in the path.
- R5: After the last fault of a kind clears, the output stays asserted for exactly HOLD_CYCLES rising clock edges. A new fault during the countdown reloads it, and counting resumes only once all rails are good again.
- R6: With `bypass` high, both outputs follow the fault conditions in the same cycle, with no hold time.
- R7: While `lockout` is high, `uv_n` is low and `ov_n` is high, and any captured overvoltage is discarded. After lockout ends, `uv_n` runs the full HOLD_CYCLES timeout.
- R8: In the latch variant (LATCH_VARIANT=1), an overvoltage seen while `latch_off` is low keeps `ov_n` low until `latch_off` goes high. With `latch_off` held high, `ov_n` uses the same timeout as `uv_n`. In this variant `dis_in` has no effect.
- R9: In the latch variant, if `latch_off` goes low while the overvoltage countdown is running, `ov_n` is captured low.
- R10: In the disable variant (LATCH_VARIANT=0), `dis_in` high holds both outputs high whatever the faults. Lockout still drives `uv_n` low, and `uv_n` returns high in the same cycle that lockout ends. In this variant `latch_off` has no effect.
- R11: During and after reset, `uv_n` is low and `ov_n` is high. `uv_n` is released HOLD_CYCLES edges after reset ends, provided lockout is low and all rails are good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_below | input | 4 | Per rail: high tap is below threshold |
| lo_above | input | 4 | Per rail: low tap is above threshold |
| pol_sel | input | 2 | Polarity code for rails 3 and 4 |
| lockout | input | 1 | Supply undervoltage lockout active |
| bypass | input | 1 | Remove the hold timeout |
| latch_off | input | 1 | Latch variant: high clears and bypasses the overvoltage latch |
| dis_in | input | 1 | Disable variant: high silences both outputs |
| uv_n | output | 1 | Active-low undervoltage fault |
| ov_n | output | 1 | Active-low overvoltage fault |

## Verification
The bench measures the release edge exactly: it checks one cycle before and one cycle after the HOLD_CYCLES boundary. An off-by-one counter, or a counter that is not reloaded by a one-cycle fault in the middle of the countdown, would release one cycle early or late. It walks every `pol_sel` code with single-bit faults on rails 3 and 4, so a wrong polarity decode or a missing swap would raise the wrong output. It drops `latch_off` in the middle of a countdown, and it raises lockout while an overvoltage is captured. A latch that only watched live faults would release after the timeout, and a latch that survived lockout would assert `ov_n` once lockout ended. It also checks that the disable variant releases `uv_n` in the same cycle lockout ends; a design that ran the timeout there would hold the output low too long.

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
  parameter int HOLD_CYCLES   = 1000,
  parameter int LATCH_VARIANT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] hi_below,
  input  logic [3:0] lo_above,
  input  logic [1:0] pol_sel,
  input  logic       lockout,
  input  logic       bypass,
  input  logic       latch_off,
  input  logic       dis_in,
  output logic       uv_n,
  output logic       ov_n
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);

  logic [3:0] neg, uv_rail, ov_rail;
  logic uv_fault, ov_fault, dis_eff, lat_en, skip;
  logic [CW-1:0] uv_cnt, ov_cnt;
  logic uv_busy, ov_busy, ov_lat, uv_act, ov_act;

  assign neg = {~pol_sel[1], (pol_sel == 2'b00), 2'b00};
  assign uv_rail = (neg & lo_above) | (~neg & hi_below);
  assign ov_rail = (neg & hi_below) | (~neg & lo_above);

  assign uv_fault = (|uv_rail) | lockout;
  assign ov_fault = (|ov_rail) & ~lockout;
  assign lat_en   = (LATCH_VARIANT != 0);
  assign dis_eff  = ~lat_en & dis_in;
  assign skip     = bypass | dis_eff;
  assign uv_busy  = (uv_cnt != '0);
  assign ov_busy  = (ov_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             uv_cnt <= HOLD_V;
    else if (skip)          uv_cnt <= '0;
    else if (uv_fault)      uv_cnt <= HOLD_V;
    else if (uv_busy)       uv_cnt <= uv_cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ov_cnt <= '0;
    else if (skip || lockout) ov_cnt <= '0;
    else if (ov_fault)        ov_cnt <= HOLD_V;
    else if (ov_busy)         ov_cnt <= ov_cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ov_lat <= 1'b0;
    else if (!lat_en || lockout || latch_off) ov_lat <= 1'b0;
    else if (ov_fault || ov_busy)          ov_lat <= 1'b1;
  end

  assign uv_act = dis_eff ? lockout : (uv_fault | (~bypass & uv_busy));
  assign ov_act = dis_eff ? 1'b0
                : (~lockout & (ov_fault | ov_lat | (~bypass & ov_busy)));
  assign uv_n = ~uv_act;
  assign ov_n = ~ov_act;

  // R7
  lockout_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (!uv_n && ov_n));
  // R4
  uv_fault_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_fault && !dis_eff) |-> !uv_n);
  // R4
  ov_fault_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ov_rail) && !lockout && !dis_eff) |-> !ov_n);
  // R5
  uv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !dis_eff && $past(!bypass && !dis_eff) && $rose(uv_n))
      |-> ($past(!uv_fault) && $past(uv_cnt) == CW'(1)));
  // R8
  ov_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_lat && !dis_eff) |-> (ov_n == lockout));
  // R10
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_eff |-> (ov_n && (uv_n == !lockout)));
endmodule

// File: tb/tb_rail_supervisor.sv
`timescale 1ns/1ps
module tb_rail_supervisor;
  localparam int HOLD = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] hi_below = '0, lo_above = '0;
  logic [1:0] pol_sel = 2'b10;
  logic lockout = 1'b0, bypass = 1'b0, latch_off = 1'b1, dis_in = 1'b0;
  logic uv_n, ov_n, uv_d, ov_d;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rail_supervisor #(.HOLD_CYCLES(HOLD), .LATCH_VARIANT(1)) dut (
    .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
    .pol_sel(pol_sel), .lockout(lockout), .bypass(bypass),
    .latch_off(latch_off), .dis_in(dis_in), .uv_n(uv_n), .ov_n(ov_n));

  rail_supervisor #(.HOLD_CYCLES(HOLD), .LATCH_VARIANT(0)) dut_dis (
    .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
    .pol_sel(pol_sel), .lockout(lockout), .bypass(bypass),
    .latch_off(latch_off), .dis_in(dis_in), .uv_n(uv_d), .ov_n(ov_d));

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic gu, logic go, logic eu, logic eo);
    checks++;
    if (gu !== eu || go !== eo) begin
      errors++;
      $display("FAIL %s: uv_n/ov_n=%b%b expected %b%b", tag, gu, go, eu, eo);
    end
  endtask

  task automatic t_reset();
    #1;
    step(2);
    chk("R11 in reset", uv_n, ov_n, 1'b0, 1'b1);
    rst_n = 1'b1;
    step(HOLD - 1);
    chk("R11 before release", uv_n, ov_n, 1'b0, 1'b1);
    step(1);
    chk("R11 released", uv_n, ov_n, 1'b1, 1'b1);
    chk("R11 disable variant released", uv_d, ov_d, 1'b1, 1'b1);
  endtask

  task automatic probe(string tag, logic [1:0] ps, logic [3:0] hb, logic [3:0] la,
                       logic eu, logic eo);
    pol_sel = ps; hi_below = hb; lo_above = la;
    #1;
    chk(tag, uv_n, ov_n, eu, eo);
    hi_below = '0; lo_above = '0;
    #1;
  endtask

  task automatic t_mapping();
    bypass = 1'b1;
    step(1);
    probe("R1 rail1 high tap", 2'b10, 4'b0001, 4'b0000, 1'b0, 1'b1);
    probe("R1 rail2 low tap",  2'b10, 4'b0000, 4'b0010, 1'b1, 1'b0);
    probe("R2 sel=10 rail4 positive", 2'b10, 4'b1000, 4'b0000, 1'b0, 1'b1);
    probe("R2 sel=11 rail3 positive", 2'b11, 4'b0000, 4'b0100, 1'b1, 1'b0);
    probe("R2 sel=01 rail3 positive", 2'b01, 4'b0100, 4'b0000, 1'b0, 1'b1);
    probe("R3 sel=01 rail4 negative hi", 2'b01, 4'b1000, 4'b0000, 1'b1, 1'b0);
    probe("R3 sel=00 rail3 negative lo", 2'b00, 4'b0000, 4'b0100, 1'b0, 1'b1);
    probe("R3 sel=00 rail4 negative hi", 2'b00, 4'b1000, 4'b0000, 1'b1, 1'b0);
    probe("R4 both kinds at once", 2'b10, 4'b0001, 4'b0100, 1'b0, 1'b0);
    hi_below = 4'b0001;
    #1;
    hi_below = '0;
    #1;
    chk("R6 bypass no hold", uv_n, ov_n, 1'b1, 1'b1);
    pol_sel = 2'b10;
    bypass = 1'b0;
    step(HOLD + 2);
  endtask

  task automatic t_hold();
    hi_below = 4'b0010;
    step(1);
    hi_below = '0;
    #1;
    chk("R5 uv held after clear", uv_n, ov_n, 1'b0, 1'b1);
    step(HOLD - 1);
    chk("R5 uv one edge before release", uv_n, ov_n, 1'b0, 1'b1);
    step(1);
    chk("R5 uv released on time", uv_n, ov_n, 1'b1, 1'b1);
    lo_above = 4'b0001;
    step(1);
    lo_above = '0;
    step(HOLD - 1);
    chk("R8 ov timeout with latch_off high", uv_n, ov_n, 1'b1, 1'b0);
    step(1);
    chk("R8 ov released with latch_off high", uv_n, ov_n, 1'b1, 1'b1);
  endtask

  task automatic t_restart();
    hi_below = 4'b0001;
    step(1);
    hi_below = '0;
    step(3);
    hi_below = 4'b0100;
    step(1);
    hi_below = '0;
    step(HOLD - 1);
    chk("R5 restart keeps uv low", uv_n, ov_n, 1'b0, 1'b1);
    step(1);
    chk("R5 restart release", uv_n, ov_n, 1'b1, 1'b1);
  endtask

  task automatic t_lockout();
    lockout = 1'b1; lo_above = 4'b0001;
    #1;
    chk("R7 lockout forces uv and blocks ov", uv_n, ov_n, 1'b0, 1'b1);
    step(2);
    lockout = 1'b0; lo_above = '0;
    step(HOLD - 1);
    chk("R7 uv timeout after lockout", uv_n, ov_n, 1'b0, 1'b1);
    step(1);
    chk("R7 uv released after lockout", uv_n, ov_n, 1'b1, 1'b1);
    latch_off = 1'b0; lo_above = 4'b0010;
    step(1);
    lo_above = '0;
    lockout = 1'b1;
    step(1);
    lockout = 1'b0;
    step(HOLD + 1);
    chk("R7 lockout discards captured ov", uv_n, ov_n, 1'b1, 1'b1);
    latch_off = 1'b1;
    step(1);
  endtask

  task automatic t_latch();
    latch_off = 1'b0; lo_above = 4'b0001;
    step(1);
    lo_above = '0;
    step(HOLD + 5);
    chk("R8 ov captured past timeout", uv_n, ov_n, 1'b1, 1'b0);
    chk("R10 disable variant ignores latch_off", uv_d, ov_d, 1'b1, 1'b1);
    latch_off = 1'b1;
    step(1);
    chk("R8 clear releases ov", uv_n, ov_n, 1'b1, 1'b1);
    lo_above = 4'b0010;
    step(1);
    lo_above = '0;
    step(3);
    latch_off = 1'b0;
    step(HOLD + 3);
    chk("R9 capture during countdown", uv_n, ov_n, 1'b1, 1'b0);
    latch_off = 1'b1;
    step(1);
    chk("R9 clear after capture", uv_n, ov_n, 1'b1, 1'b1);
  endtask

  task automatic t_disable();
    dis_in = 1'b1; hi_below = 4'b0001; lo_above = 4'b0010;
    #1;
    chk("R10 disable silences faults", uv_d, ov_d, 1'b1, 1'b1);
    chk("R8 latch variant ignores dis_in", uv_n, ov_n, 1'b0, 1'b0);
    hi_below = '0; lo_above = '0;
    lockout = 1'b1;
    step(3);
    chk("R10 lockout asserts uv under disable", uv_d, ov_d, 1'b0, 1'b1);
    lockout = 1'b0;
    #1;
    chk("R10 uv releases at once", uv_d, ov_d, 1'b1, 1'b1);
    step(1);
    dis_in = 1'b0;
    #1;
    chk("R10 clean exit from disable", uv_d, ov_d, 1'b1, 1'b1);
    step(HOLD + 1);
  endtask

  initial begin
    t_reset();
    t_mapping();
    t_hold();
    t_restart();
    t_lockout();
    t_latch();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule